// File: doc/BRIEF.md
# Half-Duplex UART Transmitter with Automatic Driver Direction

This block is the transmit half of a UART meant for two-wire, half-duplex RS-485 links. The host writes bytes into a small transmit queue. A shifter takes them one at a time and sends each as a 10-bit frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Each bit lasts one period of an external `baud_tick` strobe. When the queue still holds data as a stop bit ends, the next start bit follows with no idle gap.

When automatic direction control is enabled, the block also drives the line-driver enable. That output is active low. It goes low as soon as a byte is accepted into the queue. It goes back high one full bit time after the stop bit of the final queued frame has ended, so the driver lets go of the bus only after the far end has seen the whole frame.

The level-type transmit interrupt changes meaning with the mode. In standard mode it fires when the queue has just handed its last byte to the shifter, which leaves the host one frame of time to refill the queue. In automatic mode it waits until the shifter itself has finished. The interrupt clears on any accepted write or on an acknowledge pulse. A write to a full queue is discarded and reported on a one-cycle flag.

Top module: `txdir_uart_tx`

## Requirements
- R1: During and after a synchronous reset, `txd` is 1, `dir_n` is 1, `irq` is 0 and `wr_drop` is 0, and the queue is empty.
- R2: A queued byte starts at the first `baud_tick` after it is accepted. From that tick on, `txd` carries 0 (start bit), then data bits 0 to 7, then 1 (stop bit). Each level appears one cycle after a tick and holds until the cycle after the next tick. With nothing queued, the line stays at 1.
- R3: The queue holds `FIFO_DEPTH` bytes and sends them in write order. A write while the queue is full is discarded, and `wr_drop` is 1 for exactly the cycle after that write.
- R4: If the queue is not empty at the tick that ends a stop bit, that same tick starts the next frame's start bit, with no idle bit in between.
- R5: With `auto_dir_en`=1, `dir_n` is 0 in the cycle after any accepted write.
- R6: With `auto_dir_en`=1, `dir_n` stays 0 across back-to-back frames and through the bit time after the last stop bit. It goes to 1 one cycle after the first `baud_tick` that follows the tick ending the last stop bit.
- R7: With `auto_dir_en`=1, a write accepted during that final bit time keeps `dir_n` at 0, and the new byte is sent at the next tick.
- R8: With `auto_dir_en`=0, `irq` becomes 1 one cycle after the tick that moves the last queued byte into the shifter, while that byte's frame is still being sent.
- R9: With `auto_dir_en`=1, `irq` stays 0 while frames are in flight. It becomes 1 one cycle after the tick that ends the stop bit of the last frame.
- R10: `irq` is a level. It stays 1 until an accepted write or an `irq_ack` pulse, and it is 0 in the cycle after either.
- R11: With `auto_dir_en`=0, `dir_n` stays at 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| auto_dir_en | input | 1 | 1 = automatic driver-direction mode, 0 = standard mode |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to queue |
| irq_ack | input | 1 | Clears the transmit interrupt |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| txd | output | 1 | Serial line, idle high |
| dir_n | output | 1 | Driver enable, active low |
| irq | output | 1 | Transmit interrupt, level |
| wr_drop | output | 1 | Pulses when a write hit a full queue |

## Verification
The bench builds the block with `FIFO_DEPTH` set to 4. At that depth the full-queue drop can be reached after only a few writes, and a single chain of four back-to-back frames drains the queue completely. In both modes it sends every one of the 256 byte values and checks each bit level, along with `dir_n` and `irq` around each frame. The shallow queue also brings the refill-during-release-window case and the interrupt acknowledge within a short run.

// File: rtl/txdir_pkg.sv
`timescale 1ns/1ps
package txdir_pkg;

    localparam int unsigned DATA_W   = 8;
    localparam int unsigned FRAME_W  = DATA_W + 2;
    localparam int unsigned BITIDX_W = $clog2(FRAME_W);

    typedef logic [DATA_W-1:0]   data_t;
    typedef logic [FRAME_W-1:0]  frame_t;
    typedef logic [BITIDX_W-1:0] bitidx_t;

    // Shifter state: frame bits still to send sit LSB-first in shreg.
    typedef struct packed {
        logic    busy;
        bitidx_t bit_idx;
        frame_t  shreg;
    } shift_st_t;

    // Driver-direction state: OFF releases the bus, DRIVE holds it,
    // TAIL holds it for one more bit time after the last stop bit.
    typedef enum logic [1:0] {
        DIR_OFF   = 2'd0,
        DIR_DRIVE = 2'd1,
        DIR_TAIL  = 2'd2
    } dir_state_e;

    function automatic frame_t build_frame(input data_t d);
        return {1'b1, d, 1'b0};
    endfunction

    function automatic logic is_stop_bit(input bitidx_t idx);
        return idx == bitidx_t'(FRAME_W - 1);
    endfunction

endpackage

// File: rtl/txdir_fifo.sv
`timescale 1ns/1ps
module txdir_fifo
    import txdir_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push_req,
    input  data_t push_data,
    input  logic  pop,
    output data_t rd_data,
    output logic  empty,
    output logic  accept,
    output logic  drain,
    output logic  drop
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    data_t          mem [DEPTH];
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  count;
    logic           full;
    logic           drop_q;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign accept  = push_req && !full;
    assign drain   = pop && !accept && (count == CW'(1));
    assign rd_data = mem[rd_ptr];
    assign drop    = drop_q;

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            drop_q <= 1'b0;
        end else begin
            drop_q <= push_req && full;
            if (accept) wr_ptr <= ptr_next(wr_ptr);
            if (pop)    rd_ptr <= ptr_next(rd_ptr);
            case ({accept, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3: a rejected write must leave the queue occupancy untouched
    p_drop_keeps_count_r3: assert property (@(posedge clk) disable iff (rst)
        (push_req && full && !pop) |=> (count == $past(count)));

    // R3: rejected write raises the drop flag next cycle
    p_drop_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (push_req && full) |=> drop);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

endmodule

// File: rtl/txdir_shifter.sv
`timescale 1ns/1ps
module txdir_shifter
    import txdir_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  q_empty,
    input  data_t q_data,
    output logic  pop,
    output logic  done,
    output logic  busy,
    output logic  txd
);
    shift_st_t st;
    logic      at_stop;

    assign at_stop = is_stop_bit(st.bit_idx);
    assign pop     = tick && !q_empty && (!st.busy || at_stop);
    assign done    = tick && st.busy && at_stop && q_empty;
    assign busy    = st.busy;
    assign txd     = st.busy ? st.shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{busy: 1'b0, bit_idx: '0, shreg: '1};
        end else if (tick) begin
            if (pop) begin
                st <= '{busy: 1'b1, bit_idx: '0, shreg: build_frame(q_data)};
            end else if (st.busy) begin
                if (at_stop) begin
                    st.busy <= 1'b0;
                end else begin
                    st.shreg   <= {1'b1, st.shreg[FRAME_W-1:1]};
                    st.bit_idx <= st.bit_idx + 1'b1;
                end
            end
        end
    end

    // R2: every frame opens with a low start bit
    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd);

    // R2: the line only moves on a bit boundary
    p_bit_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(txd));

endmodule

// File: rtl/txdir_dirctl.sv
`timescale 1ns/1ps
module txdir_dirctl
    import txdir_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic auto_en,
    input  logic wr_acc,
    input  logic tick,
    input  logic done,
    input  logic drain,
    input  logic ack,
    output logic dir_n,
    output logic irq
);
    dir_state_e st;
    logic       irq_q;
    logic       set_evt;

    assign dir_n   = (st == DIR_OFF);
    assign irq     = irq_q;
    assign set_evt = auto_en ? done : drain;

    always_ff @(posedge clk) begin
        if (rst || !auto_en) begin
            st <= DIR_OFF;
        end else if (wr_acc) begin
            st <= DIR_DRIVE;
        end else begin
            case (st)
                DIR_DRIVE: if (done) st <= DIR_TAIL;
                DIR_TAIL:  if (tick) st <= DIR_OFF;
                default:   st <= st;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if (wr_acc) begin
            irq_q <= 1'b0;
        end else if (set_evt) begin
            irq_q <= 1'b1;
        end else if (ack) begin
            irq_q <= 1'b0;
        end
    end

    // R5: an accepted byte grabs the bus on the next cycle
    p_dir_low_after_write_r5: assert property (@(posedge clk) disable iff (rst)
        (auto_en && wr_acc) |=> !dir_n);

    // R11: standard mode never drives the direction pin
    p_std_dir_high_r11: assert property (@(posedge clk) disable iff (rst)
        !auto_en |=> dir_n);

    // R10: a queued write always withdraws the interrupt
    p_irq_clear_r10: assert property (@(posedge clk) disable iff (rst)
        wr_acc |=> !irq);

    // R8: standard mode flags the queue draining into the shifter
    p_std_irq_r8: assert property (@(posedge clk) disable iff (rst)
        (!auto_en && drain) |=> irq);

    // R9: automatic mode flags only the end of the last frame
    p_auto_irq_r9: assert property (@(posedge clk) disable iff (rst)
        (auto_en && done && !wr_acc) |=> irq);

endmodule

// File: rtl/txdir_uart_tx.sv
`timescale 1ns/1ps
module txdir_uart_tx
    import txdir_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              auto_dir_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_ack,
    input  logic              baud_tick,
    output logic              txd,
    output logic              dir_n,
    output logic              irq,
    output logic              wr_drop
);
    data_t q_data;
    logic  q_empty, q_accept, q_drain;
    logic  sh_pop, sh_done, sh_busy;

    txdir_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push_req  (wr_en),
        .push_data (wr_data),
        .pop       (sh_pop),
        .rd_data   (q_data),
        .empty     (q_empty),
        .accept    (q_accept),
        .drain     (q_drain),
        .drop      (wr_drop)
    );

    txdir_shifter u_shifter (
        .clk     (clk),
        .rst     (rst),
        .tick    (baud_tick),
        .q_empty (q_empty),
        .q_data  (q_data),
        .pop     (sh_pop),
        .done    (sh_done),
        .busy    (sh_busy),
        .txd     (txd)
    );

    txdir_dirctl u_dirctl (
        .clk     (clk),
        .rst     (rst),
        .auto_en (auto_dir_en),
        .wr_acc  (q_accept),
        .tick    (baud_tick),
        .done    (sh_done),
        .drain   (q_drain),
        .ack     (irq_ack),
        .dir_n   (dir_n),
        .irq     (irq)
    );

    // R6: once driving in automatic mode, a busy shifter keeps the bus held
    p_hold_while_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (auto_dir_en && sh_busy && !dir_n) |=> (!dir_n || !auto_dir_en));

    // R4: a frame ending with data queued restarts immediately
    p_no_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (sh_busy && sh_pop) |=> (sh_busy && !txd));

endmodule

// File: tb/txdir_uart_tx_bench.sv
`timescale 1ns/1ps
module txdir_uart_tx_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       auto_dir_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       irq_ack = 1'b0;
    logic       baud_tick = 1'b0;
    logic       txd, dir_n, irq, wr_drop;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    txdir_uart_tx #(.FIFO_DEPTH(4)) u_txdir_uart_tx (
        .clk(clk), .rst(rst), .auto_dir_en(auto_dir_en), .wr_en(wr_en),
        .wr_data(wr_data), .irq_ack(irq_ack), .baud_tick(baud_tick),
        .txd(txd), .dir_n(dir_n), .irq(irq), .wr_drop(wr_drop)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        baud_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        baud_tick = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        wr_en = 1'b1;
        wr_data = b;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    // Ten ticks of one frame; the first tick is the one that starts it.
    task automatic expect_frame(input logic [7:0] b, input logic am, input logic last);
        logic exp_bit;
        for (int i = 0; i < 10; i++) begin
            tick();
            exp_bit = (i == 0) ? 1'b0 : ((i <= 8) ? b[i-1] : 1'b1);
            chk("R2 frame bit", txd, exp_bit);
            chk(am ? "R6 dir held" : "R11 dir released", dir_n, am ? 0 : 1);
            if (i == 0 && last && !am) chk("R8 irq on drain", irq, 1);
            if (am || !last) chk(am ? "R9 irq held off" : "R8 irq early", irq, 0);
        end
        if (last) begin
            tick();
            chk("R2 idle after stop", txd, 1);
            chk(am ? "R9 irq at end" : "R10 irq level", irq, 1);
            chk(am ? "R6 dir in tail" : "R11 dir released", dir_n, am ? 0 : 1);
            tick();
            chk("R6 dir release", dir_n, 1);
            chk("R10 irq level", irq, 1);
            chk("R2 idle line", txd, 1);
        end
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        n_errors++;
        $display("FAIL watchdog: got %0d expected %0d cycles", cycles, 100000);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] bytes [4];
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 txd", txd, 1);
        chk("R1 dir_n", dir_n, 1);
        chk("R1 irq", irq, 0);
        chk("R1 wr_drop", wr_drop, 0);
        rst = 1'b0;
        @(negedge clk);
        tick();
        chk("R1 empty queue idle", txd, 1);

        // Exhaustive byte sweep in both modes
        for (int m = 0; m < 2; m++) begin
            auto_dir_en = m[0];
            @(negedge clk);
            for (int v = 0; v < 256; v++) begin
                push(v[7:0]);
                chk(m[0] ? "R5 dir on write" : "R11 dir released", dir_n, m[0] ? 0 : 1);
                chk("R10 write clears irq", irq, 0);
                expect_frame(v[7:0], m[0], 1'b1);
            end
        end

        // R10: level holds, acknowledge clears
        tick();
        chk("R10 irq holds", irq, 1);
        ack_pulse();
        chk("R10 ack clears", irq, 0);
        tick();
        chk("R10 stays clear", irq, 0);

        // R3/R4: fill queue, overflow dropped, back-to-back order preserved
        for (int m = 0; m < 2; m++) begin
            auto_dir_en = m[0];
            @(negedge clk);
            bytes[0] = 8'h3A; bytes[1] = 8'hC5; bytes[2] = 8'h81; bytes[3] = 8'h7E;
            for (int k = 0; k < 4; k++) begin
                push(bytes[k] ^ m[7:0]);
                chk("R3 no drop below full", wr_drop, 0);
            end
            push(8'h00);
            chk("R3 drop flag", wr_drop, 1);
            @(negedge clk);
            chk("R3 drop one cycle", wr_drop, 0);
            for (int k = 0; k < 4; k++) begin
                expect_frame(bytes[k] ^ m[7:0], m[0], k == 3);
            end
        end

        // R4: refill while sending keeps frames contiguous
        auto_dir_en = 1'b1;
        @(negedge clk);
        push(8'h96);
        tick();
        chk("R2 start", txd, 0);
        push(8'h69);
        for (int i = 1; i < 10; i++) tick();
        chk("R4 stop before next", txd, 1);
        expect_frame(8'h69, 1'b1, 1'b1);

        // R7: write during the release window keeps the bus
        push(8'h3C);
        expect_frame(8'h3C, 1'b1, 1'b0);
        tick();
        chk("R9 irq at end", irq, 1);
        chk("R6 tail held", dir_n, 0);
        push(8'hC3);
        chk("R7 dir kept", dir_n, 0);
        chk("R10 write clears", irq, 0);
        expect_frame(8'hC3, 1'b1, 1'b1);

        // R11: leaving auto mode releases the bus immediately
        push(8'h55);
        chk("R5 dir on write", dir_n, 0);
        auto_dir_en = 1'b0;
        @(negedge clk);
        chk("R11 dir released", dir_n, 1);
        expect_frame(8'h55, 1'b0, 1'b1);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule